// File: doc/BRIEF.md
# Loopback Tail-Capture Receive FIFO

This block is the receive half of a loopback FIFO. The transmit half is not part of it. While a packet is being received, every byte is written into an eight-entry circular store. When the packet ends, only the final eight bytes are left, which are the tail of the payload and the check sequence. At the end of the packet the read pointer is loaded with the position of the oldest retained byte. A host can then walk through the retained bytes in order by reading a single byte-wide data output. The data path is eight bits wide only.

Each host read is marked by a strobe that is asynchronous to the controller clock. The strobe passes through a flop-chain synchronizer, and the read pointer advances one position when the synchronized strobe shows a rising edge. From the moment the strobe rises until that advance has happened, the block holds a wait output high. A host that reads again too early is therefore stretched until the data register holds the next byte.

For packets shorter than eight bytes, a valid-count output tells the host how many retained bytes belong to the packet. The positions beyond that count still hold bytes from earlier traffic.

Top module: `lbk_tail_fifo`

## Requirements
- R1: While reset is high and after it is released, `valid_cnt` is 0, `rd_wait` is 0 and `rd_data` is 0x00.
- R2: Each clock edge with `rx_valid` high writes `rx_data` into the store. `valid_cnt` rises by one per byte and saturates at 8.
- R3: When `rx_valid` and `rx_eop` are high together, that byte closes the packet. For a packet of 8 or more bytes, `rd_data` then shows the byte received 8 positions before the end. Each later read shows the next byte, up to the last byte received.
- R4: After a packet of N < 8 bytes closes, `valid_cnt` equals N. The first N reads return the N bytes in arrival order.
- R5: If `host_rd` rises before clock edge k, the pointer advances exactly once, and `rd_data` changes after edge k+2. It does not change after edge k or k+1. A strobe that is held high gives no further advance.
- R6: `rd_wait` goes high as soon as `host_rd` is high and stays high until the edge that advances the pointer. It is low after that edge and low while no read is pending.
- R7: The read pointer wraps modulo 8. The ninth read after an 8-or-more-byte packet returns the same byte as the first read.
- R8: The first byte after a closed packet starts a new packet, so `valid_cnt` becomes 1.
- R9: `rx_eop` with `rx_valid` low is ignored. `valid_cnt` and `rd_data` are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | Qualified by `rx_valid`: this byte is the last of the packet |
| host_rd | input | 1 | Asynchronous host read strobe, active high |
| rd_data | output | 8 | Byte at the current read position |
| rd_wait | output | 1 | Wait-state request: read pointer not yet advanced |
| valid_cnt | output | 4 | Number of retained bytes belonging to the last packet (0 to 8) |

## Verification
Every packet length from 1 to 20 bytes is sent, each with its own byte pattern, so the start position in the circular store moves from packet to packet. Short lengths separate the partial-fill reload (R4) from the full-tail reload (R3). Lengths above 8 show whether older bytes were overwritten correctly and whether the reload points at the oldest survivor. The ninth read separates pointer wrap from overrun. Each read is checked edge by edge, so a pointer that moves one cycle early or late, or a wait flag that drops before the advance, shows up as a mismatch. A lone end-of-packet marker is inserted before every read-out to show that it is ignored.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  last;
        byte_t data;
    } rx_beat_t;

    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/lbk_strobe_sync.sv
module lbk_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_async,
    output logic adv_pulse,
    output logic busy
);
    logic [STAGES-1:0] chain;
    logic              seen;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= strobe_async;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= 1'b0;
            else     chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= chain[STAGES-1];
    end

    assign adv_pulse = chain[STAGES-1] & ~seen;
    assign busy      = (strobe_async | (|chain)) & ~seen;

endmodule

// File: rtl/lbk_tail_store.sv
module lbk_tail_store
    import lbk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_vld,
    input  rx_beat_t         beat,
    input  logic [PTR_W-1:0] rd_sel,
    output byte_t            rd_byte,
    output logic [CNT_W-1:0] cnt,
    output logic             closed,
    output logic             load_vld,
    output logic [PTR_W-1:0] load_ptr
);
    byte_t            mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [CNT_W-1:0] cnt_next;
    logic [PTR_W-1:0] wptr_next;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= '0;
            else if (beat_vld && wptr == PTR_W'(g))
                mem[g] <= beat.data;
        end
    end

    always_comb begin
        wptr_next = wptr + PTR_W'(1);
        if (closed)
            cnt_next = CNT_W'(1);
        else if (cnt == CNT_W'(DEPTH))
            cnt_next = cnt;
        else
            cnt_next = cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            cnt    <= '0;
            closed <= 1'b0;
        end else if (beat_vld) begin
            wptr   <= wptr_next;
            cnt    <= cnt_next;
            closed <= beat.last;
        end
    end

    assign load_vld = beat_vld & beat.last;
    assign load_ptr = wptr_next - PTR_W'(cnt_next);
    assign rd_byte  = mem[rd_sel];

endmodule

// File: rtl/lbk_rd_ptr.sv
module lbk_rd_ptr #(
    parameter int PTR_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_vld,
    input  logic [PTR_W-1:0] load_ptr,
    input  logic             adv,
    output logic [PTR_W-1:0] rptr
);
    always_ff @(posedge clk) begin
        if (rst)
            rptr <= '0;
        else if (load_vld)
            rptr <= load_ptr;
        else if (adv)
            rptr <= rptr + PTR_W'(1);
    end
endmodule

// File: rtl/lbk_tail_fifo.sv
module lbk_tail_fifo
    import lbk_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2,
    localparam int PTR_W      = ptr_width(DEPTH),
    localparam int CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_eop,
    input  logic              host_rd,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_wait,
    output logic [CNT_W-1:0]  valid_cnt
);
    rx_beat_t         beat;
    logic             adv;
    logic             pkt_closed;
    logic             load_vld;
    logic [PTR_W-1:0] load_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign beat.last = rx_eop;
    assign beat.data = rx_data;

    lbk_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst          (rst),
        .strobe_async (host_rd),
        .adv_pulse    (adv),
        .busy         (rd_wait)
    );

    lbk_tail_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .beat_vld (rx_valid),
        .beat     (beat),
        .rd_sel   (rd_ptr),
        .rd_byte  (rd_data),
        .cnt      (valid_cnt),
        .closed   (pkt_closed),
        .load_vld (load_vld),
        .load_ptr (load_ptr)
    );

    lbk_rd_ptr #(.PTR_W(PTR_W)) u_rptr (
        .clk      (clk),
        .rst      (rst),
        .load_vld (load_vld),
        .load_ptr (load_ptr),
        .adv      (adv),
        .rptr     (rd_ptr)
    );

endmodule

// File: rtl/lbk_tail_fifo_chk.sv
module lbk_tail_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             rx_eop,
    input logic             rd_wait,
    input logic [CNT_W-1:0] valid_cnt,
    input logic             pkt_closed,
    input logic [PTR_W-1:0] rd_ptr
);
    // R2: the count never exceeds the store depth
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        valid_cnt <= CNT_W'(DEPTH));

    // R2: a byte inside an open packet below the depth raises the count by one
    a_r2_cnt_step: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !pkt_closed && valid_cnt < CNT_W'(DEPTH))
        |=> valid_cnt == $past(valid_cnt) + CNT_W'(1));

    // R8: the first byte after a closed packet restarts the count
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && pkt_closed) |=> valid_cnt == CNT_W'(1));

    // R9: an end marker without a byte leaves the count alone
    a_r9_lone_eop: assert property (@(posedge clk) disable iff (rst)
        (rx_eop && !rx_valid) |=> $stable(valid_cnt));

    // R5: without a reload the pointer holds or steps by exactly one
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_eop)
        |=> (rd_ptr == $past(rd_ptr) || rd_ptr == $past(rd_ptr) + PTR_W'(1)));

    // R6: right after a strobe-driven advance the wait request is released
    a_r6_wait_released: assert property (@(posedge clk) disable iff (rst)
        (!(rx_valid && rx_eop) ##1 rd_ptr != $past(rd_ptr)) |-> !rd_wait);

endmodule

bind lbk_tail_fifo lbk_tail_fifo_chk #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .rx_eop     (rx_eop),
    .rd_wait    (rd_wait),
    .valid_cnt  (valid_cnt),
    .pkt_closed (pkt_closed),
    .rd_ptr     (rd_ptr)
);

// File: tb/lbk_tail_fifo_tb.sv
module lbk_tail_fifo_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_eop;
    logic       host_rd;
    logic [7:0] rd_data;
    logic       rd_wait;
    logic [3:0] valid_cnt;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    logic [7:0] exp_tail [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    lbk_tail_fifo u_dut (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_eop    (rx_eop),
        .host_rd   (host_rd),
        .rd_data   (rd_data),
        .rd_wait   (rd_wait),
        .valid_cnt (valid_cnt)
    );

    function automatic logic [7:0] byte_of(input int seed, input int idx);
        return 8'((seed * 13 + idx * 29 + 5) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_pkt(input int len, input int seed, input bit first);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = byte_of(seed, i);
            rx_eop   = (i == len - 1);
            @(negedge clk);
            if (i == 0 && !first)
                check("R8 count restart", int'(valid_cnt), 1);
            else
                check("R2 count", int'(valid_cnt), (i + 1 < DEPTH) ? i + 1 : DEPTH);
        end
        rx_valid = 1'b0;
        rx_eop   = 1'b0;
        rx_data  = 8'h00;
    endtask

    // Data is checked, then the strobe is raised and the advance timed.
    task automatic host_read(input string req, input logic [7:0] exp);
        check(req, int'(rd_data), int'(exp));
        host_rd = 1'b1;
        #1;
        check("R6 wait on strobe", int'(rd_wait), 1);
        @(negedge clk);
        check("R5 no move after edge k", int'(rd_data), int'(exp));
        check("R6 wait held", int'(rd_wait), 1);
        @(negedge clk);
        check("R5 no move after edge k+1", int'(rd_data), int'(exp));
        check("R6 wait held", int'(rd_wait), 1);
        @(negedge clk);
        check("R6 wait released", int'(rd_wait), 0);
        @(negedge clk);
        host_rd = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 idle wait low", int'(rd_wait), 0);
    endtask

    initial begin
        rst      = 1'b1;
        rx_valid = 1'b0;
        rx_data  = 8'h00;
        rx_eop   = 1'b0;
        host_rd  = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(valid_cnt), 0);
        check("R1 reset wait", int'(rd_wait), 0);
        check("R1 reset data", int'(rd_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release count", int'(valid_cnt), 0);
        check("R1 after release data", int'(rd_data), 0);

        for (int len = 1; len <= 20; len++) begin
            int seed;
            int n;
            seed = len * 7 + 3;
            n    = (len < DEPTH) ? len : DEPTH;
            for (int k = 0; k < n; k++)
                exp_tail[k] = byte_of(seed, len - n + k);

            send_pkt(len, seed, len == 1);
            @(negedge clk);

            check(len < DEPTH ? "R4 short count" : "R2 saturated count",
                  int'(valid_cnt), n);

            // R9: lone end marker
            rx_eop = 1'b1;
            @(negedge clk);
            rx_eop = 1'b0;
            @(negedge clk);
            check("R9 lone eop count", int'(valid_cnt), n);
            check("R9 lone eop data", int'(rd_data), int'(exp_tail[0]));

            if (len >= DEPTH) begin
                for (int k = 0; k < DEPTH; k++)
                    host_read("R3 tail byte", exp_tail[k]);
                host_read("R7 wrap to first", exp_tail[0]);
            end else begin
                for (int k = 0; k < n; k++)
                    host_read("R4 short byte", exp_tail[k]);
            end
        end

        // R5: a strobe held high advances only once
        send_pkt(10, 99, 1'b0);
        @(negedge clk);
        host_rd = 1'b1;
        repeat (12) @(negedge clk);
        check("R5 held strobe single step", int'(rd_data), int'(byte_of(99, 3)));
        host_rd = 1'b0;
        repeat (4) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule